// File: doc/BRIEF.md
# Flash Buffered-Program Sequencer

This block runs the multi-write buffered-program sequence of a NOR flash device. A command decoder passes it every write strobe with its address and data. A setup command, written while the block is idle, opens a sequence and records the write address as the buffer base. The next write gives the entry count. A run of data writes then fills a buffer of up to 32 entries. A final confirm write either commits the buffer to the array or throws it away.

While a sequence is open, every read returns the busy status code. When the confirm byte matches, the stored entries go out on an array write port, one entry per clock, at consecutive addresses starting from the base. A one-cycle completion pulse then tells the decoder to return to array-read mode.

The controller has five states. `ST_IDLE` waits for the setup command. `ST_COUNT` waits for the count write. `ST_FILL` collects data writes. `ST_CONFIRM` waits for the confirm write. `ST_COMMIT` streams the buffer to the array. Its transitions are:
- Setup write: `ST_IDLE` to `ST_COUNT`.
- Any write: `ST_COUNT` to `ST_FILL`.
- The last in-window data write: `ST_FILL` to `ST_CONFIRM`.
- Matching confirm byte: `ST_CONFIRM` to `ST_COMMIT`.
- Any other confirm byte: `ST_CONFIRM` to `ST_IDLE`.
- Last entry streamed: `ST_COMMIT` to `ST_IDLE`.

Top module: `fwb_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `arr_we` are low, and `rdata` is 0.
- R2: While idle, a write whose data bits [7:0] equal 0xE8 opens a sequence and latches `addr` as the base. A write with any other low byte leaves the block idle, so a following read returns 0.
- R3: The first write after setup sets the entry count to `wdata[4:0] + 1`, giving 1 to 32 entries. The upper data bits are ignored.
- R4: A data write is stored at entry index `addr - base` (modulo 2^16) only when that difference is below the count. A write outside that window is ignored and does not count toward the total.
- R5: After `count` accepted data writes, the block waits for a confirm write. A confirm whose data bits [7:0] equal 0xD0 starts the commit.
- R6: The commit drives `arr_we` for exactly `count` consecutive cycles, with `busy` high during the same cycles. In cycle i it drives `arr_addr = base + i` and `arr_wdata` = the entry stored at index i.
- R7: `done` is high for exactly one cycle, in the cycle after the last commit cycle. The block is then idle.
- R8: A confirm write with any other low byte discards the buffer. No array write occurs, `done` pulses in the next cycle, and the block is idle.
- R9: While a sequence is open (any state other than idle), a read returns 0x0080 on `rdata`. An idle read returns 0.
- R10: Writes made during the commit are ignored. In particular, a setup byte written then does not open a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the command decoder |
| rd_en | input | 1 | Read strobe from the command decoder |
| addr | input | 16 | Word address of the access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Status read data |
| busy | output | 1 | Commit in progress |
| done | output | 1 | One-cycle pulse when the sequence ends |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 16 | Array write address |
| arr_wdata | output | 16 | Array write data |

## Verification
The assertions assume the decoder does not assert `wr_en` and `rd_en` together. They also assume a commit only begins after a full setup, count and fill sequence, so consecutive array writes are always preceded by that setup. The bench drives at most one strobe per cycle.

The bench sweeps every count from 1 to 32. For each count it uses a different base, fills the buffer forward or in reverse, and mixes in out-of-window writes before and after the base. Every fifth sequence is closed with a non-matching confirm byte, so the discard path is exercised alongside the commit path.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_FILL,
        ST_CONFIRM,
        ST_COMMIT
    } fwb_state_e;
endpackage

// File: rtl/fwb_window.sv
// Address window test: hit when (addr - base) mod 2^AW is below count.
module fwb_window #(
    parameter int AW = 16,
    parameter int IW = 5,
    localparam int CW = IW + 1
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    output logic          hit,
    output logic [IW-1:0] offset
);
    logic [AW-1:0] diff;

    always_comb begin
        diff   = addr - base;
        hit    = (diff < AW'(count));
        offset = diff[IW-1:0];
    end
endmodule

// File: rtl/fwb_buffer.sv
// Entry storage: one register per entry, a single write port and a single read port.
module fwb_buffer #(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && (widx == IW'(e))) begin
                mem_q[e] <= wdata;
            end
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/fwb_sequencer.sv
module fwb_sequencer #(
    parameter int         AW        = 16,
    parameter int         DW        = 16,
    parameter int         DEPTH     = 32,
    parameter logic [7:0] CMD_SETUP = 8'hE8,
    parameter logic [7:0] CMD_GO    = 8'hD0,
    parameter logic [7:0] STAT_BUSY = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          busy,
    output logic          done,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata
);
    import fwb_pkg::*;

    localparam int IW = $clog2(DEPTH);
    localparam int CW = IW + 1;

    fwb_state_e    state_q, state_d;
    logic [AW-1:0] base_q;
    logic [CW-1:0] count_q, remain_q;
    logic [IW-1:0] idx_q;
    logic          done_q;

    logic          win_hit;
    logic [IW-1:0] win_off;
    logic          buf_we;
    logic [CW-1:0] req_len;
    logic          last_entry;
    logic [7:0]    wr_low;

    assign wr_low     = wdata[7:0];
    assign req_len    = {1'b0, wdata[IW-1:0]} + CW'(1);
    assign last_entry = (CW'(idx_q) == (count_q - CW'(1)));

    fwb_window #(.AW(AW), .IW(IW)) win_i (
        .addr   (addr),
        .base   (base_q),
        .count  (count_q),
        .hit    (win_hit),
        .offset (win_off)
    );

    assign buf_we = (state_q == ST_FILL) && wr_en && win_hit;

    fwb_buffer #(.DW(DW), .DEPTH(DEPTH)) buf_i (
        .clk   (clk),
        .we    (buf_we),
        .widx  (win_off),
        .wdata (wdata),
        .ridx  (idx_q),
        .rdata (arr_wdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (wr_en && wr_low == CMD_SETUP) state_d = ST_COUNT;
            ST_COUNT:   if (wr_en) state_d = ST_FILL;
            ST_FILL:    if (buf_we && remain_q == CW'(1)) state_d = ST_CONFIRM;
            ST_CONFIRM: if (wr_en) state_d = (wr_low == CMD_GO) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT:  if (last_entry) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Sequence bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            count_q  <= '0;
            remain_q <= '0;
            idx_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_en && wr_low == CMD_SETUP) begin
                        base_q   <= addr;
                        count_q  <= '0;
                        remain_q <= '0;
                    end
                end
                ST_COUNT: begin
                    if (wr_en) begin
                        count_q  <= req_len;
                        remain_q <= req_len;
                    end
                end
                ST_FILL: begin
                    if (buf_we) remain_q <= remain_q - CW'(1);
                end
                ST_CONFIRM: begin
                    idx_q <= '0;
                    if (wr_en && wr_low != CMD_GO) done_q <= 1'b1;
                end
                ST_COMMIT: begin
                    idx_q <= idx_q + IW'(1);
                    if (last_entry) done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q == ST_COMMIT);
        arr_we   = busy;
        arr_addr = base_q + AW'(idx_q);
        done     = done_q;
        rdata    = (rd_en && state_q != ST_IDLE) ? DW'(STAT_BUSY) : '0;
    end
endmodule

// File: rtl/fwb_sequencer_chk.sv
module fwb_sequencer_chk #(
    parameter int         AW        = 16,
    parameter int         DW        = 16,
    parameter int         DEPTH     = 32,
    parameter logic [7:0] STAT_BUSY = 8'h80
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic [DW-1:0] rdata,
    input logic          busy,
    input logic          done,
    input logic          arr_we,
    input logic [AW-1:0] arr_addr
);
    localparam int RW = $clog2(DEPTH + 1) + 1;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + RW'(1);
        else           run_q <= '0;
    end

    AST_WE_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) arr_we == busy); // R6
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> run_q < RW'(DEPTH)); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (arr_we && $past(arr_we)) |-> arr_addr == $past(arr_addr) + AW'(1)); // R6
    AST_DONE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R7
    AST_BUSY_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && busy) |-> rdata == DW'(STAT_BUSY)); // R9
endmodule

bind fwb_sequencer fwb_sequencer_chk #(
    .AW(AW), .DW(DW), .DEPTH(DEPTH), .STAT_BUSY(STAT_BUSY)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .busy     (busy),
    .done     (done),
    .arr_we   (arr_we),
    .arr_addr (arr_addr)
);

// File: tb/fwb_sequencer_tb.sv
module fwb_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXN       = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy, done, arr_we;
    logic [15:0] arr_addr, arr_wdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwb_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy),
        .done(done), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [15:0] exp, input string tag);
        rd_en = 1'b1;
        #1;
        chk(rdata === exp, tag, rdata, exp);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] exp_mem [MAXN];
        @(negedge clk); @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && done === 1'b0 && arr_we === 1'b0, "R1 reset outputs", {busy, done, arr_we}, 0);
        rd_check(16'h0000, "R1 reset read");
        rst_n = 1'b1;
        @(negedge clk);
        rd_check(16'h0000, "R1 idle read");

        // R2: non-setup write in idle is ignored
        wr(16'h0100, 16'h00D0);
        rd_check(16'h0000, "R2 non-setup ignored");
        wr(16'h0100, 16'hE800);
        rd_check(16'h0000, "R2 setup byte in high half ignored");

        for (int n = 1; n <= MAXN; n++) begin
            logic [15:0] base;
            bit          discard;
            bit          poke;
            base    = 16'(n * 613 + 7);
            discard = (n % 5 == 4);
            poke    = (n % 7 == 3);
            // R2: setup
            wr(base, {8'(n), 8'hE8});
            rd_check(16'h0080, "R9 read after setup");
            // R3: count, upper bits set to exercise masking
            wr(16'h5555, {3'(n), 8'hA5, 5'(n - 1)});
            rd_check(16'h0080, "R9 read in fill");
            // R4: out-of-window writes, must be neither stored nor counted
            wr(base - 16'd1, 16'hDEAD);
            wr(base + 16'(n), 16'hBEEF);
            wr(base + 16'd40, 16'hD0D0);
            for (int k = 0; k < n; k++) begin
                int i;
                i = (n % 2 == 1) ? (n - 1 - k) : k;
                exp_mem[i] = 16'(n * 1000 + i * 37 + 3);
                wr(base + 16'(i), exp_mem[i]);
            end
            // R5: waiting for confirm, still reading busy status
            rd_check(16'h0080, "R5 read while awaiting confirm");
            if (discard) begin
                wr(16'h0000, 16'h00D1);
                // R8
                chk(done === 1'b1 && arr_we === 1'b0 && busy === 1'b0, "R8 discard done pulse", {done, arr_we, busy}, 3'b100);
                @(negedge clk);
                chk(done === 1'b0 && arr_we === 1'b0, "R8 no array write after discard", {done, arr_we}, 0);
                rd_check(16'h0000, "R8 idle after discard");
            end else begin
                wr(16'h0000, 16'h33D0);
                for (int i = 0; i < n; i++) begin
                    // R6: one entry per cycle
                    chk(arr_we === 1'b1 && busy === 1'b1, "R6 commit enable", {arr_we, busy}, 2'b11);
                    chk(arr_addr === base + 16'(i), "R6 commit address", arr_addr, base + 16'(i));
                    chk(arr_wdata === exp_mem[i], "R4 R6 commit data", arr_wdata, exp_mem[i]);
                    chk(done === 1'b0, "R7 no early done", done, 0);
                    if (i == 0) begin
                        rd_en = 1'b1; #1;
                        chk(rdata === 16'h0080, "R9 read during commit", rdata, 16'h0080);
                        rd_en = 1'b0;
                        if (poke) begin
                            wr_en = 1'b1; addr = 16'h0200; wdata = 16'h00E8; // R10 setup during commit
                        end
                    end
                    @(negedge clk);
                    wr_en = 1'b0;
                end
                // R7
                chk(done === 1'b1 && busy === 1'b0 && arr_we === 1'b0, "R7 done pulse", {done, busy, arr_we}, 3'b100);
                @(negedge clk);
                chk(done === 1'b0, "R7 done single cycle", done, 0);
                rd_check(16'h0000, poke ? "R10 write during commit ignored" : "R7 idle after commit");
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule